// File: doc/BRIEF.md
# Reflected CRC-16 byte accumulator

This block keeps a running 16-bit cyclic redundancy check over a stream of bytes that a host or a DMA engine writes one per strobe. The generator is the CCITT polynomial x^16 + x^12 + x^5 + 1. Each byte is folded in least-significant bit first, and the remainder is kept and presented in reflected (bit-reversed) order. This is the LSB-first form of the CCITT code that serial links use.

Software first writes a seed into the result register, or relies on the zero value it holds after reset. It then pushes bytes in transmission order and reads the result. All eight bits of a byte are processed in one clock. The block takes one byte per cycle and has no timing that depends on the clock frequency, so it behaves the same on a fast main clock and on a slow auxiliary clock.

Top module: `crc16r_accum`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the result `crc_q` to 0x0000.
- R2: A byte strobe (`byte_we` high, `seed_we` low) at a rising edge updates the result at that edge, so it can be read in the next cycle. Strobes on consecutive cycles are each accepted, one byte per clock.
- R3: From a zero result, writing the bytes 0x78, 0x56, 0x34, 0x12 in that order leaves 0x08F6.
- R4: Bits are consumed least-significant first with reflected polynomial 0x8408. From a zero result, the byte 0x01 gives 0x1189 and the byte 0x80 gives 0x8408.
- R5: A seed strobe (`seed_we` high) loads `seed_data` into the result at that edge.
- R6: When `seed_we` and `byte_we` are both high at the same edge, the seed is loaded and the byte is discarded.
- R7: With neither strobe high, the result holds its value.
- R8: For any seed and any byte sequence, the result equals the MSB-first CCITT remainder of the bit-reversed bytes, started from the bit-reversed seed and read back bit-reversed.
- R9: From a zero result, the byte 0x00 leaves the result at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| byte_we | input | 1 | Byte write strobe |
| byte_data | input | 8 | Byte folded into the CRC |
| seed_we | input | 1 | Result register write strobe (seed load) |
| seed_data | input | 16 | Seed value to load |
| crc_q | output | 16 | Current reflected CRC remainder |

## Verification
The assertions assume that both strobes and both data buses hold known, stable values across each rising edge, and that reset is applied synchronously for at least one edge before the first strobe. The fixed-value properties look only at cycles that start from a zero remainder. The bench meets these conditions: it drives every input on the falling edge, holds a strobe for exactly one rising edge unless it is deliberately running back-to-back bytes, and reads `crc_q` on the following falling edge. The collision and idle cases are produced on purpose, so the load-priority and hold properties each have their antecedent met at least once.

// File: rtl/crc16r_pkg.sv
package crc16r_pkg;
    localparam int unsigned CRC_W_DEF  = 16;
    localparam int unsigned DATA_W_DEF = 8;
    // x^16 + x^12 + x^5 + 1 written in reflected form
    localparam logic [CRC_W_DEF-1:0] POLY_REFL_DEF = 16'h8408;
    localparam logic [CRC_W_DEF-1:0] INIT_DEF      = 16'h0000;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_FOLD = 2'd1,
        OP_LOAD = 2'd2
    } crc_op_e;
endpackage

// File: rtl/crc16r_bitstep.sv
module crc16r_bitstep #(
    parameter int unsigned           CRC_W = crc16r_pkg::CRC_W_DEF,
    parameter logic [CRC_W-1:0]      POLY  = crc16r_pkg::POLY_REFL_DEF
) (
    input  logic [CRC_W-1:0] rem_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] rem_out
);
    logic feedback;

    always_comb begin
        feedback = rem_in[0] ^ bit_in;
        rem_out  = (rem_in >> 1) ^ (feedback ? POLY : '0);
    end
endmodule

// File: rtl/crc16r_bytestep.sv
module crc16r_bytestep #(
    parameter int unsigned      CRC_W  = crc16r_pkg::CRC_W_DEF,
    parameter int unsigned      DATA_W = crc16r_pkg::DATA_W_DEF,
    parameter logic [CRC_W-1:0] POLY   = crc16r_pkg::POLY_REFL_DEF
) (
    input  logic [CRC_W-1:0]  rem_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  rem_out
);
    localparam int unsigned STAGES = DATA_W;

    logic [STAGES:0][CRC_W-1:0] chain;

    assign chain[0] = rem_in;

    // bit 0 of the byte enters first (LSB-first)
    for (genvar g = 0; g < STAGES; g++) begin : g_bit
        crc16r_bitstep #(
            .CRC_W (CRC_W),
            .POLY  (POLY)
        ) i_step (
            .rem_in  (chain[g]),
            .bit_in  (data_in[g]),
            .rem_out (chain[g+1])
        );
    end

    assign rem_out = chain[STAGES];
endmodule

// File: rtl/crc16r_ctrl.sv
module crc16r_ctrl (
    input  logic                  byte_we,
    input  logic                  seed_we,
    output crc16r_pkg::crc_op_e   op
);
    import crc16r_pkg::*;

    always_comb begin
        // a seed load outranks a byte in the same cycle
        if (seed_we)      op = OP_LOAD;
        else if (byte_we) op = OP_FOLD;
        else              op = OP_HOLD;
    end
endmodule

// File: rtl/crc16r_accum.sv
module crc16r_accum #(
    parameter int unsigned      CRC_W     = crc16r_pkg::CRC_W_DEF,
    parameter int unsigned      DATA_W    = crc16r_pkg::DATA_W_DEF,
    parameter logic [CRC_W-1:0] POLY_REFL = crc16r_pkg::POLY_REFL_DEF,
    parameter logic [CRC_W-1:0] INIT_VAL  = crc16r_pkg::INIT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_we,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              seed_we,
    input  logic [CRC_W-1:0]  seed_data,
    output logic [CRC_W-1:0]  crc_q
);
    import crc16r_pkg::*;

    typedef struct packed {
        logic [CRC_W-1:0] rem;
    } state_t;

    state_t              st_d, st_q;
    crc_op_e             op;
    logic [CRC_W-1:0]    folded;

    crc16r_ctrl i_ctrl (
        .byte_we (byte_we),
        .seed_we (seed_we),
        .op      (op)
    );

    crc16r_bytestep #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY_REFL)
    ) i_fold (
        .rem_in  (st_q.rem),
        .data_in (byte_data),
        .rem_out (folded)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: st_d.rem = seed_data;
            OP_FOLD: st_d.rem = folded;
            default: st_d.rem = st_q.rem;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{rem: INIT_VAL};
        else     st_q <= st_d;
    end

    assign crc_q = st_q.rem;
endmodule

// File: rtl/crc16r_accum_chk.sv
module crc16r_accum_chk (
    input logic        clk,
    input logic        rst,
    input logic        byte_we,
    input logic [7:0]  byte_data,
    input logic        seed_we,
    input logic [15:0] seed_data,
    input logic [15:0] crc_q
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> crc_q == 16'h0000);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!byte_we && !seed_we) |=> $stable(crc_q));

    assert_seed_load_R5: assert property (@(posedge clk) disable iff (rst)
        seed_we |=> crc_q == $past(seed_data));

    assert_seed_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (seed_we && byte_we) |=> crc_q == $past(seed_data));

    assert_lsb_first_R4: assert property (@(posedge clk) disable iff (rst)
        (byte_we && !seed_we && crc_q == 16'h0000 && byte_data == 8'h01)
        |=> crc_q == 16'h1189);

    assert_zero_byte_R9: assert property (@(posedge clk) disable iff (rst)
        (byte_we && !seed_we && crc_q == 16'h0000 && byte_data == 8'h00)
        |=> crc_q == 16'h0000);

    assert_byte_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (byte_we && !seed_we && crc_q == 16'h0000 && byte_data != 8'h00)
        |=> crc_q != 16'h0000);
endmodule

bind crc16r_accum crc16r_accum_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .byte_we   (byte_we),
    .byte_data (byte_data),
    .seed_we   (seed_we),
    .seed_data (seed_data),
    .crc_q     (crc_q)
);

// File: tb/test_crc16r_accum.sv
module test_crc16r_accum;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        byte_we;
    logic [7:0]  byte_data;
    logic        seed_we;
    logic [15:0] seed_data;
    logic [15:0] crc_q;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc16r_accum i_crc16r_accum (
        .clk       (clk),
        .rst       (rst),
        .byte_we   (byte_we),
        .byte_data (byte_data),
        .seed_we   (seed_we),
        .seed_data (seed_data),
        .crc_q     (crc_q)
    );

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    function automatic logic [15:0] rev16(input logic [15:0] v);
        for (int i = 0; i < 16; i++) rev16[i] = v[15-i];
    endfunction

    // MSB-first CCITT on reversed data, result reversed back
    function automatic logic [15:0] ref_step(input logic [15:0] r, input logic [7:0] b);
        logic [15:0] m;
        logic [7:0]  d;
        logic        fb;
        m = rev16(r);
        d = rev8(b);
        for (int i = 7; i >= 0; i--) begin
            fb = m[15] ^ d[i];
            m  = {m[14:0], 1'b0};
            if (fb) m = m ^ 16'h1021;
        end
        return rev16(m);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: crc_q=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        byte_we = 1'b1; byte_data = b;
        @(negedge clk);
        byte_we = 1'b0;
    endtask

    task automatic put_seed(input logic [15:0] s);
        @(negedge clk);
        seed_we = 1'b1; seed_data = s;
        @(negedge clk);
        seed_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_R1();
        put_seed(16'hBEEF);
        do_reset();
        check("R1 reset value", crc_q, 16'h0000);
    endtask

    task automatic t_vector_R3();
        do_reset();
        put_byte(8'h78); put_byte(8'h56); put_byte(8'h34); put_byte(8'h12);
        check("R3 fixed vector", crc_q, 16'h08F6);
    endtask

    task automatic t_single_R4_R9();
        do_reset();
        put_byte(8'h01);
        check("R4 byte 0x01", crc_q, 16'h1189);
        do_reset();
        put_byte(8'h80);
        check("R4 byte 0x80", crc_q, 16'h8408);
        do_reset();
        put_byte(8'h00);
        check("R9 zero byte", crc_q, 16'h0000);
    endtask

    task automatic t_seed_R5();
        put_seed(16'h1234);
        check("R5 seed load", crc_q, 16'h1234);
        put_byte(8'hA5);
        check("R5 fold after seed", crc_q, ref_step(16'h1234, 8'hA5));
    endtask

    task automatic t_collision_R6();
        put_seed(16'h0F0F);
        @(negedge clk);
        seed_we = 1'b1; seed_data = 16'hC3C3;
        byte_we = 1'b1; byte_data = 8'h5A;
        @(negedge clk);
        seed_we = 1'b0; byte_we = 1'b0;
        check("R6 seed wins", crc_q, 16'hC3C3);
    endtask

    task automatic t_hold_R7();
        logic [15:0] held;
        put_seed(16'h7E81);
        held = crc_q;
        byte_data = 8'hFF; seed_data = 16'h0000;
        repeat (5) @(negedge clk);
        check("R7 idle hold", crc_q, held);
    endtask

    task automatic t_back_to_back_R2();
        logic [15:0] exp;
        do_reset();
        exp = 16'h0000;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i > 0) check("R2 per-cycle update", crc_q, exp);
            byte_we = 1'b1; byte_data = 8'(i * 37 + 3);
            exp = ref_step(exp, byte_data);
        end
        @(negedge clk);
        byte_we = 1'b0;
        check("R2 last byte", crc_q, exp);
    endtask

    task automatic t_random_R8();
        logic [15:0] exp;
        logic [15:0] s;
        int          len;
        for (int run = 0; run < 40; run++) begin
            s = 16'($urandom);
            put_seed(s);
            exp = s;
            len = 1 + int'($urandom_range(30));
            for (int k = 0; k < len; k++) begin
                @(negedge clk);
                byte_we = 1'b1; byte_data = 8'($urandom);
                exp = ref_step(exp, byte_data);
                @(negedge clk);
                byte_we = 1'b0;
                check("R8 random stream", crc_q, exp);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: crc_q=%h expected=finish", crc_q);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; byte_we = 1'b0; seed_we = 1'b0;
        byte_data = 8'h00; seed_data = 16'h0000;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 initial reset", crc_q, 16'h0000);
        t_reset_R1();
        t_vector_R3();
        t_single_R4_R9();
        t_seed_R5();
        t_collision_R6();
        t_hold_R7();
        t_back_to_back_R2();
        t_random_R8();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule